// File: doc/BRIEF.md
# Pipelined Floating-Point Multiplier Core

This block multiplies two floating-point operands whose exponent and fraction widths are set by parameters, so that both the common 32-bit and 64-bit layouts, as well as narrower custom formats, come from the same code. Each operand arrives with its leading one already made explicit in the significand. The block does no rounding and no normalization. It delivers the product sign, the biased exponent sum with one bias taken away, and the complete double-width significand product. A separate rounding stage downstream is expected to consume these results.

Operands enter on every clock if needed. A valid strobe and an exception flag travel next to the data through three register stages, so each result leaves with its own markers. An operand whose exponent and significand are both zero counts as zero, and it forces an all-zero result. An exponent that falls outside the representable range raises the exception flag.

Top module: `fp_pipe_mul`

## Requirements
- R1: The result sign equals the XOR of the two operand signs whenever neither operand is zero.
- R2: The result exponent equals the low EXP_W bits of ea + eb - BIAS, where BIAS = 2^(EXP_W-1) - 1 (127 for EXP_W = 8).
- R3: The result significand is the full unsigned product of the two (MAN_W+1)-bit significands, 2*(MAN_W+1) bits wide, with no rounding or shifting.
- R4: A pair sampled with in_valid high at a clock edge produces its result exactly 3 edges later, and a new pair may be given at every edge.
- R5: out_valid is in_valid delayed by exactly 3 clock edges, and no result appears without an accepted pair.
- R6: in_exc is delayed by 3 edges and ORed into out_exc, aligned with the result of the same pair.
- R7: An operand with exponent 0 and significand 0 is zero. If either operand is zero, res_sign, res_exp and res_man are all 0, and exponent range errors of that pair do not raise out_exc.
- R8: For non-zero operands, ea + eb - BIAS greater than 2^EXP_W - 1 sets out_exc.
- R9: For non-zero operands, ea + eb less than BIAS sets out_exc.
- R10: A synchronous active-high reset clears out_valid and out_exc on the next edge, and drops pairs that are still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| in_exc | input | 1 | Exception flag from upstream |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | EXP_W | Biased exponent of operand A |
| a_man | input | MAN_W+1 | Significand of A with explicit leading one |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | EXP_W | Biased exponent of operand B |
| b_man | input | MAN_W+1 | Significand of B with explicit leading one |
| out_valid | output | 1 | Result present |
| out_exc | output | 1 | Upstream exception OR range error |
| res_sign | output | 1 | Product sign |
| res_exp | output | EXP_W | Biased product exponent, not normalized |
| res_man | output | 2*(MAN_W+1) | Full significand product |

## Verification
Zero forcing and exponent range detection can both apply to the same pair. A zero operand carries exponent 0, so pairing it with a small non-zero exponent also meets the underflow condition. Pairing it with an upstream exception tests whether that flag still gets through. The bench drives these mixed pairs back to back with ordinary pairs. It expects an all-zero result, and it expects out_exc to equal in_exc alone, not the range error.

// File: rtl/fp_pipe_mul.sv
module fp_pipe_mul #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     in_exc,
  input  logic                     a_sign,
  input  logic [EXP_W-1:0]         a_exp,
  input  logic [MAN_W:0]           a_man,
  input  logic                     b_sign,
  input  logic [EXP_W-1:0]         b_exp,
  input  logic [MAN_W:0]           b_man,
  output logic                     out_valid,
  output logic                     out_exc,
  output logic                     res_sign,
  output logic [EXP_W-1:0]         res_exp,
  output logic [2*(MAN_W+1)-1:0]   res_man
);
  localparam int SIG_W  = MAN_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int SUM_W  = EXP_W + 1;
  localparam logic [SUM_W-1:0] BIAS_V = SUM_W'((1 << (EXP_W - 1)) - 1);
  localparam logic [SUM_W-1:0] HI_LIM = BIAS_V + SUM_W'((1 << EXP_W) - 1);

  wire a_zero   = (a_exp == '0) && (a_man == '0);
  wire b_zero   = (b_exp == '0) && (b_man == '0);
  wire any_zero = a_zero | b_zero;

  // stage 1: capture operands, add exponents, flag zeros
  logic             s1_vld, s1_exc, s1_sign, s1_zero;
  logic [SUM_W-1:0] s1_esum;
  logic [MAN_W:0]   s1_ma, s1_mb;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_exc <= 1'b0;
    end else begin
      s1_vld <= in_valid;
      s1_exc <= in_exc;
    end
    s1_sign <= a_sign ^ b_sign;
    s1_zero <= any_zero;
    s1_esum <= {1'b0, a_exp} + {1'b0, b_exp};
    s1_ma   <= a_man;
    s1_mb   <= b_man;
  end

  // stage 2: multiply significands, remove bias, range check
  logic              s2_vld, s2_exc, s2_sign, s2_zero, s2_range;
  logic [EXP_W-1:0]  s2_exp;
  logic [PROD_W-1:0] s2_prod;
  logic [SUM_W-1:0]  unbiased;

  assign unbiased = s1_esum - BIAS_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld <= 1'b0;
      s2_exc <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
      s2_exc <= s1_exc;
    end
    s2_sign  <= s1_sign;
    s2_zero  <= s1_zero;
    s2_exp   <= unbiased[EXP_W-1:0];
    s2_range <= (s1_esum < BIAS_V) || (s1_esum > HI_LIM);
    s2_prod  <= PROD_W'(s1_ma) * PROD_W'(s1_mb);
  end

  // stage 3: zero mux and exception merge
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_exc   <= 1'b0;
    end else begin
      out_valid <= s2_vld;
      out_exc   <= s2_exc | (s2_range & ~s2_zero);
    end
    res_sign <= s2_zero ? 1'b0 : s2_sign;
    res_exp  <= s2_zero ? '0 : s2_exp;
    res_man  <= s2_zero ? '0 : s2_prod;
  end

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R10
  always @(negedge clk) begin
    if (rst_q === 1'b1) begin
      reset_clear_chk: assert (out_valid == 1'b0 && out_exc == 1'b0);
    end
  end

  // R5
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid, 3) |-> out_valid);

  // R6
  exc_pass_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_exc, 3) && out_valid) |-> out_exc);

  // R7
  zero_force_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(any_zero, 3)) |-> (res_man == '0 && res_exp == '0 && !res_sign));

  // R1
  sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(any_zero, 3)) |-> (res_sign == ($past(a_sign, 3) ^ $past(b_sign, 3))));
endmodule

// File: tb/fp_pipe_mul_tb.sv
module fp_pipe_mul_tb;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int SIG_W = MAN_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX = (1 << EXP_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_exc = 1'b0;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [EXP_W-1:0] a_exp = '0, b_exp = '0;
  logic [MAN_W:0] a_man = '0, b_man = '0;
  logic out_valid, out_exc, res_sign;
  logic [EXP_W-1:0] res_exp;
  logic [PROD_W-1:0] res_man;

  always #5 clk = ~clk;

  fp_pipe_mul #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_exc(in_exc),
    .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
    .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
    .out_valid(out_valid), .out_exc(out_exc), .res_sign(res_sign),
    .res_exp(res_exp), .res_man(res_man));

  typedef struct {
    logic              sgn;
    logic [EXP_W-1:0]  ex;
    logic [PROD_W-1:0] mn;
    logic              exc;
    int                cyc;
  } exp_t;

  exp_t sb[$];
  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic drive(input logic sa, input logic [EXP_W-1:0] ea, input logic [MAN_W:0] ma,
                       input logic sbn, input logic [EXP_W-1:0] eb, input logic [MAN_W:0] mb,
                       input logic xin);
    exp_t e;
    int sum;
    bit zero;
    @(negedge clk);
    in_valid = 1'b1; in_exc = xin;
    a_sign = sa; a_exp = ea; a_man = ma;
    b_sign = sbn; b_exp = eb; b_man = mb;
    zero = (ea == 0 && ma == 0) || (eb == 0 && mb == 0);
    sum = int'(ea) + int'(eb) - BIAS;
    e.sgn = zero ? 1'b0 : (sa ^ sbn);
    e.ex  = zero ? '0 : sum[EXP_W-1:0];
    e.mn  = zero ? '0 : PROD_W'(ma) * PROD_W'(mb);
    e.exc = xin | (!zero && (sum < 0 || sum > EMAX));
    e.cyc = cyc + 3;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_exc = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R5", "unexpected out_valid", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.cyc, "R4", "latency cycle", 64'(cyc), 64'(e.cyc));
        check(res_sign == e.sgn, "R1", "sign", 64'(res_sign), 64'(e.sgn));
        check(res_exp == e.ex, "R2", "exponent", 64'(res_exp), 64'(e.ex));
        check(res_man == e.mn, "R3", "significand", 64'(res_man), 64'(e.mn));
        check(out_exc == e.exc, "R6", "exception", 64'(out_exc), 64'(e.exc));
      end
    end
  end

  localparam logic [MAN_W:0] ONE  = {1'b1, {MAN_W{1'b0}}};
  localparam logic [MAN_W:0] FULL = {(MAN_W+1){1'b1}};

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(out_valid == 0 && out_exc == 0, "R10", "reset outputs", {out_valid, out_exc}, 64'd0);
    @(negedge clk); rst = 1'b0;

    // R1 R2 R3: 1.0 * 1.0, signs mixed
    drive(1'b0, 8'd127, ONE, 1'b1, 8'd127, ONE, 1'b0);
    drive(1'b1, 8'd130, FULL, 1'b1, 8'd100, FULL, 1'b0);
    drive(1'b0, 8'd200, 24'hC00000, 1'b0, 8'd60, 24'hA00001, 1'b1); // R6
    idle(2);
    // R8 overflow, R9 underflow
    drive(1'b0, 8'd254, ONE, 1'b0, 8'd254, ONE, 1'b0);
    drive(1'b1, 8'd1, FULL, 1'b0, 8'd1, ONE, 1'b0);
    drive(1'b0, 8'd255, ONE, 1'b0, 8'd127, ONE, 1'b0); // sum-bias = 255, in range
    drive(1'b0, 8'd63, ONE, 1'b0, 8'd64, ONE, 1'b0);   // sum = bias, in range
    drive(1'b0, 8'd63, ONE, 1'b0, 8'd63, ONE, 1'b0);   // R9 by one
    drive(1'b0, 8'd255, ONE, 1'b0, 8'd128, ONE, 1'b0); // R8 by one
    // R7 zero operands mixed with range error and upstream exception
    drive(1'b1, 8'd0, '0, 1'b1, 8'd5, FULL, 1'b0);
    drive(1'b1, 8'd250, FULL, 1'b0, 8'd0, '0, 1'b1);
    drive(1'b0, 8'd0, '0, 1'b1, 8'd0, '0, 1'b0);
    drive(1'b1, 8'd254, ONE, 1'b1, 8'd254, ONE, 1'b1);
    idle(1);
    // R4 back-to-back random pairs
    for (int i = 0; i < 60; i++) begin
      logic [MAN_W:0] ma, mb;
      ma = {1'b1, MAN_W'($urandom)};
      mb = {1'b1, MAN_W'($urandom)};
      drive(1'($urandom), EXP_W'($urandom), (i % 11 == 0) ? '0 : ma,
            1'($urandom), EXP_W'($urandom), mb, 1'($urandom % 5 == 0));
      if (i % 11 == 0) a_exp = '0;
      if (i % 11 == 0) begin
        exp_t e;
        e = sb.pop_back();
        e.sgn = 1'b0; e.ex = '0; e.mn = '0; e.exc = in_exc;
        sb.push_back(e);
      end
    end
    idle(6);
    check(sb.size() == 0, "R5", "results missing", 64'(sb.size()), 64'd0);

    // R10 reset drops in-flight pairs
    drive(1'b0, 8'd127, ONE, 1'b0, 8'd127, ONE, 1'b1);
    drive(1'b0, 8'd127, ONE, 1'b0, 8'd127, ONE, 1'b1);
    @(negedge clk); in_valid = 1'b0; in_exc = 1'b0; rst = 1'b1;
    sb.delete();
    @(negedge clk);
    check(out_valid == 0 && out_exc == 0, "R10", "flush after reset", {out_valid, out_exc}, 64'd0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(5);
    check(out_valid == 0, "R10", "no stale result", 64'(out_valid), 64'd0);
    drive(1'b1, 8'd128, ONE, 1'b0, 8'd128, FULL, 1'b0);
    idle(5);
    check(sb.size() == 0, "R4", "post-reset result", 64'(sb.size()), 64'd0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      check(1'b0, "R4", "watchdog expired", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule